// File: doc/BRIEF.md
# I2C Serial EEPROM Target Model

This block is a synthesizable stand-in for a 256-byte serial EEPROM on an I2C bus. It is meant as a bus target when a master design is being proven out. It runs from a fast system clock and oversamples SCL and SDA. It recognises START and STOP conditions and answers only to its own 7-bit device address. It drives SDA open-drain: it pulls the line low for ACK bits and for zero data bits, and it only ever releases the line for ones.

A write transfer carries the device address with R/W=0, then a one-byte word address, then any number of data bytes. A read transfer carries the device address with R/W=1. Reads start at the internal address counter and continue through successive locations for as long as the master acknowledges. A random read is a write transfer that stops after the word address, followed by a repeated START and a read. Storage is an internal register array. A reset clears the address counter but keeps the stored bytes.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when bits 7:4 equal 1010 and bits 3:1 equal the `strap` pins (bit 0 is R/W, 1 = read). On any other address byte it leaves SDA released, acknowledges nothing more and changes no storage until the next START.
- R2: A write transfer of device address, word address, one data byte and STOP stores that byte at the word address, and every byte of the transfer is acknowledged.
- R3: Further data bytes in the same write transfer go to the following addresses within the same 8-byte page (the page is selected by address bits 7:3).
- R4: In a write, only address bits 2:0 advance. A ninth or later byte wraps to the start of the same page and overwrites what was written there, and the bytes of other pages are left unchanged.
- R5: A random read (write of a word address, repeated START, address byte with R/W=1) returns the byte stored at that word address.
- R6: A read that is not preceded by a word address returns the byte at the internal counter. That counter points one past the last byte read, or one past the last byte written within its page.
- R7: While the master acknowledges each read byte, the block sends the next location, and the address wraps from 255 to 0.
- R8: After the master NACKs a read byte, the block releases SDA and sends nothing more.
- R9: A repeated START in the middle of a byte abandons that byte without storing it. Data bytes that were already acknowledged stay stored, and the block then takes the next byte as an address byte.
- R10: The block changes its SDA drive only while SCL is low.
- R11: After reset SDA is released and the address counter is 0, and the memory contents are kept across the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | I2C clock line as seen on the bus |
| sdaIn | input | 1 | I2C data line as seen on the bus (wired-AND value) |
| strap | input | 3 | Low three device-address bits |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest situation to reach from the pins is a repeated START that lands partway through a data byte, after earlier bytes of the same transfer were already acknowledged. The bench builds this with a bit-level master task: it sends only four bits of a byte, raises SDA while SCL is low, and issues a START. It then reads back both the committed location and the location the partial byte would have hit. Page wrap and the 255-to-0 read wrap are reached on purpose: one write starts near the end of a page and carries more than eight bytes, and a sequential read runs across the whole array. A seeded random mix of page writes and random reads then runs against a byte-array model kept in the bench.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Strobes from the bus controller to the storage datapath.
  typedef struct packed {
    logic shiftIn;   // shift rxBit into the byte register
    logic rxBit;     // synchronized SDA value
    logic loadAddr;  // byte register -> address counter
    logic writeMem;  // byte register -> memory, advance within page
    logic loadTx;    // memory -> byte register, advance counter
    logic shiftTx;   // move next transmit bit into the MSB
  } dpCmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WORD, S_WORD_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK
  } busState_t;

endpackage

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output logic [DATA_W-1:0] shiftReg,
  output logic              txBit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] shiftQ;
  logic [PAGE_W-1:0] pageLow;

  assign pageLow  = addrQ[PAGE_W-1:0] + PAGE_W'(1);
  assign shiftReg = shiftQ;
  assign txBit    = shiftQ[DATA_W-1];

  // Storage keeps its contents across reset.
  always_ff @(posedge clk) begin
    if (cmd.writeMem) mem[addrQ] <= shiftQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      shiftQ <= '1;
    end else begin
      if (cmd.loadAddr)      addrQ <= shiftQ[ADDR_W-1:0];
      else if (cmd.writeMem) addrQ <= {addrQ[ADDR_W-1:PAGE_W], pageLow};
      else if (cmd.loadTx)   addrQ <= addrQ + ADDR_W'(1);

      if (cmd.shiftIn)      shiftQ <= {shiftQ[DATA_W-2:0], cmd.rxBit};
      else if (cmd.loadTx)  shiftQ <= mem[addrQ];
      else if (cmd.shiftTx) shiftQ <= {shiftQ[DATA_W-2:0], 1'b1};
    end
  end

  // R4: a stored byte never moves the counter out of its page
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeMem |=> addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W]));

  // R7: each fetched read byte steps the counter by one, modulo the depth
  p_read_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadTx |=> addrQ == $past(addrQ) + ADDR_W'(1));

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              CODE_W   = 4,
  parameter int              STRAP_W  = 3,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  shiftReg,
  input  logic               txBit,
  output dpCmd_t             cmd,
  output logic               sdaOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclS, sdaS;
  logic sclRise, sclFall, startCond, stopCond;

  busState_t stateQ, stateD;
  logic [CNT_W-1:0] bitCnt, cntD;
  logic rwQ, rwD, mAckQ, mAckD;
  logic addrHit;

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startCond = sclS & sclQ & sdaQ & ~sdaS;
  assign stopCond  = sclS & sclQ & ~sdaQ & sdaS;
  assign addrHit   = shiftReg[DATA_W-1:1] == {DEV_CODE, strap};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1; sclQ <= 1'b1; sdaQ <= 1'b1;
      stateQ  <= S_IDLE; bitCnt <= '0; rwQ <= 1'b0; mAckQ <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
      stateQ  <= stateD;
      bitCnt  <= cntD;
      rwQ     <= rwD;
      mAckQ   <= mAckD;
    end
  end

  always_comb begin
    stateD    = stateQ;
    cntD      = bitCnt;
    rwD       = rwQ;
    mAckD     = mAckQ;
    cmd       = '0;
    cmd.rxBit = sdaS;
    if (startCond) begin
      stateD = S_DEV;
      cntD   = '0;
    end else if (stopCond) begin
      stateD = S_IDLE;
    end else begin
      case (stateQ)
        S_DEV, S_WORD, S_WDATA: begin
          if (sclRise && bitCnt != FULL) begin
            cmd.shiftIn = 1'b1;
            cntD        = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == FULL) begin
            cntD = '0;
            if (stateQ == S_DEV) begin
              if (addrHit) begin
                rwD    = shiftReg[0];
                stateD = S_DEV_ACK;
              end else begin
                stateD = S_IDLE;
              end
            end else if (stateQ == S_WORD) begin
              cmd.loadAddr = 1'b1;
              stateD       = S_WORD_ACK;
            end else begin
              cmd.writeMem = 1'b1;
              stateD       = S_WDATA_ACK;
            end
          end
        end
        S_DEV_ACK: begin
          if (sclFall) begin
            if (rwQ) begin
              cmd.loadTx = 1'b1;
              stateD     = S_RDATA;
            end else begin
              stateD = S_WORD;
            end
          end
        end
        S_WORD_ACK, S_WDATA_ACK: begin
          if (sclFall) stateD = S_WDATA;
        end
        S_RDATA: begin
          if (sclFall) begin
            cmd.shiftTx = 1'b1;
            cntD        = bitCnt + CNT_W'(1);
            if (bitCnt == LAST) begin
              cntD   = '0;
              stateD = S_RACK;
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            mAckD = ~sdaS;
          end else if (sclFall) begin
            if (mAckQ) begin
              cmd.loadTx = 1'b1;
              stateD     = S_RDATA;
            end else begin
              stateD = S_IDLE;
            end
          end
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  assign sdaOe = (stateQ == S_DEV_ACK) || (stateQ == S_WORD_ACK) ||
                 (stateQ == S_WDATA_ACK) || ((stateQ == S_RDATA) && !txBit);

  // R10: drive level is held for as long as sampled SCL stays high
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclQ) |-> $stable(sdaOe));

  // R8: a STOP always leaves the line released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> !sdaOe);

  // R1: a foreign address byte gets no acknowledge
  p_no_foreign_ack_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DEV && sclFall && bitCnt == FULL && !addrHit) |=> !sdaOe);

  // R9: datapath actions never overlap in one cycle
  p_single_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.shiftIn, cmd.loadAddr, cmd.writeMem, cmd.loadTx, cmd.shiftTx}));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 3,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  output logic               sdaOe
);
  dpCmd_t            cmd;
  logic [DATA_W-1:0] shiftReg;
  logic              txBit;

  eeprom_ctrl #(
    .DATA_W(DATA_W), .CODE_W(4), .STRAP_W(STRAP_W), .DEV_CODE(4'b1010)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .strap(strap),
    .shiftReg(shiftReg), .txBit(txBit), .cmd(cmd), .sdaOe(sdaOe)
  );

  eeprom_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .shiftReg(shiftReg), .txBit(txBit)
  );

endmodule

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;
  localparam int HALF = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaOe, sdaLine;
  assign sdaLine = mSda & ~sdaOe;

  eeprom_i2c_slave dut (
    .clk(clk), .rstN(rstN), .scl(mScl), .sdaIn(sdaLine),
    .strap(STRAP), .sdaOe(sdaOe)
  );

  int nChk = 0, nFail = 0, edgeViol = 0;
  logic [7:0] refMem [256];
  logic [7:0] refAddr = 8'h00;
  logic [7:0] wbuf [16];
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R10 monitor: drive must not change while SCL stays high
  logic pScl = 1'b1, pOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && mScl && pScl && (sdaOe != pOe)) edgeViol++;
    pScl = mScl;
    pOe  = sdaOe;
  end

  function automatic logic [7:0] inPage(input logic [7:0] a, input int k);
    return {a[7:3], 3'(int'(a[2:0]) + k)};
  endfunction

  task automatic busStart();
    mSda = 1'b1; hold(HALF); mScl = 1'b1; hold(HALF);
    mSda = 1'b0; hold(HALF); mScl = 1'b0; hold(HALF);
  endtask

  task automatic busStop();
    mSda = 1'b0; hold(HALF); mScl = 1'b1; hold(HALF); mSda = 1'b1; hold(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      mSda = b[i]; hold(HALF); mScl = 1'b1; hold(HALF); mScl = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    mSda = 1'b1; hold(HALF); mScl = 1'b1; hold(HALF / 2);
    @(negedge clk); ack = ~sdaLine;
    hold(HALF / 2); mScl = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    b = '0;
    mSda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(HALF); mScl = 1'b1; hold(HALF / 2);
      @(negedge clk); b = {b[6:0], sdaLine};
      hold(HALF / 2); mScl = 1'b0;
    end
    mSda = ~ackIt; hold(HALF); mScl = 1'b1; hold(HALF); mScl = 1'b0;
    mSda = 1'b1;
  endtask

  // Write wbuf[0..n-1] starting at a, update model.
  task automatic writeSeq(input logic [7:0] a, input int n, input string req);
    logic ack;
    busStart();
    sendByte(DEV_W, ack); chk({req, " address ack"}, ack, 1);
    sendByte(a, ack);     chk({req, " word ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], ack); chk({req, " data ack"}, ack, 1);
      refMem[inPage(a, k)] = wbuf[k];
    end
    busStop();
    refAddr = inPage(a, n);
  endtask

  // Read n bytes; random read from a when setAddr, else current address.
  task automatic readSeq(input logic [7:0] a, input int n, input bit setAddr,
                         input string req);
    logic ack;
    logic [7:0] got;
    busStart();
    if (setAddr) begin
      sendByte(DEV_W, ack); chk({req, " dummy-write ack"}, ack, 1);
      sendByte(a, ack);     chk({req, " word ack"}, ack, 1);
      busStart();
      refAddr = a;
    end
    sendByte(DEV_R, ack); chk({req, " read address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, got);
      chk({req, " read data"}, got, refMem[refAddr]);
      refAddr = refAddr + 8'd1;
    end
    hold(HALF); @(negedge clk);
    chk("R8 released after NACK", sdaOe, 0);
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] got;
    void'($urandom(32'd1957));
    hold(5);
    @(negedge clk); chk("R11 reset release", sdaOe, 0);
    rstN = 1'b1; hold(5);

    // R3: fill every page with a computed pattern
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = 8'((p * 8 + k) * 7 + 3);
      writeSeq(8'(p * 8), 8, "R3");
    end
    // R7: full sweep plus wrap 255 -> 0 -> 1
    readSeq(8'h00, 258, 1'b1, "R7");

    // R2 / R5: byte write then random read
    wbuf[0] = 8'h5A; wbuf[1] = 8'h00;
    writeSeq(8'h10, 1, "R2");
    writeSeq(8'h11, 1, "R2");
    readSeq(8'h10, 1, 1'b1, "R5");

    // R4: ten bytes from 0x23 wrap within page 0x20..0x27
    for (int k = 0; k < 10; k++) wbuf[k] = 8'hC0 + 8'(k);
    writeSeq(8'h23, 10, "R4");
    readSeq(8'h20, 8, 1'b1, "R4");
    readSeq(8'h28, 1, 1'b1, "R4 neighbour page");

    // R6: current-address read continues at counter (0x29)
    readSeq(8'h00, 2, 1'b0, "R6");

    // R1: foreign strap and foreign code are ignored
    busStart();
    sendByte({4'b1010, 3'b010, 1'b0}, ack); chk("R1 foreign strap ack", ack, 0);
    sendByte(8'h30, ack); chk("R1 ignored word", ack, 0);
    sendByte(8'hEE, ack); chk("R1 ignored data", ack, 0);
    busStop();
    busStart();
    sendByte({4'b0110, STRAP, 1'b0}, ack); chk("R1 foreign code ack", ack, 0);
    sendByte(8'h31, ack); chk("R1 ignored word", ack, 0);
    sendByte(8'hEE, ack); chk("R1 ignored data", ack, 0);
    busStop();
    readSeq(8'h30, 2, 1'b1, "R1 storage untouched");

    // R9: repeated start in the middle of a data byte
    busStart();
    sendByte(DEV_W, ack); chk("R9 address ack", ack, 1);
    sendByte(8'h40, ack); chk("R9 word ack", ack, 1);
    sendByte(8'h11, ack); chk("R9 data ack", ack, 1);
    refMem[8'h40] = 8'h11;
    sendBits(8'h22, 4);
    busStart();
    sendByte(DEV_R, ack); chk("R9 address after restart", ack, 1);
    recvByte(1'b0, got);
    chk("R9 current byte after abort", got, refMem[8'h41]);
    busStop();
    readSeq(8'h40, 2, 1'b1, "R9 committed and untouched");

    // R11: reset clears counter, keeps storage
    rstN = 1'b0; hold(4);
    @(negedge clk); chk("R11 released in reset", sdaOe, 0);
    rstN = 1'b1; hold(4);
    refAddr = 8'h00;
    readSeq(8'h00, 1, 1'b0, "R11 counter zero");

    // Random mix of page writes and random reads
    for (int it = 0; it < 14; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        n = $urandom_range(1, 12);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        writeSeq(a, n, "R3 random");
      end else begin
        n = $urandom_range(1, 4);
        readSeq(a, n, 1'b1, "R5 random");
      end
    end

    chk("R10 drive changes with SCL high", edgeViol, 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule